// File: doc/BRIEF.md
# Oscillator Startup and Wake Timer

This block holds the CPU clock off after the oscillator starts, until that clock can be trusted. It runs after a reset, and again every time the chip leaves power-down. On a power-down request it turns the oscillator off and clears its settle counter. A wake request, already qualified upstream, turns the oscillator back on at once. The CPU clock enable then stays low while a 10-bit counter counts oscillator clocks up to a settle length that depends on the clock source in use.

Crystal sources need the longer wait of 1024 clocks. The on-chip RC oscillator and an external clock input need only 256. A 3-bit source-select code tells the block which kind is fitted, and any code it does not recognise gets the safe, longer wait. The code is captured on the first counting clock of each settle period, so a later change cannot shorten or lengthen a count already in progress. Once the settle count completes, the CPU clock enable stays high until the next power-down.

Top module: `osc_wake_timer`

## Requirements
- R1: While reset is asserted and on leaving it, oscEn is 1, cpuClkEn is 0 and pdFlag is 0. A settle count then starts, and cpuClkEn rises after exactly the settle length in clock edges.
- R2: srcSel codes 3'b000, 3'b001 and 3'b010 (the crystal ranges) and the unused codes 3'b100, 3'b101 and 3'b110 give a settle length of 1024 clocks.
- R3: srcSel code 3'b011 (internal RC) and code 3'b111 (external clock) give a settle length of 256 clocks.
- R4: A pdReq sampled while cpuClkEn is 1 makes oscEn and cpuClkEn 0 and pdFlag 1 on the next clock. That state is held for as long as no wakeReq arrives.
- R5: A wakeReq sampled during power-down makes oscEn 1 and pdFlag 0 on the next clock, with cpuClkEn still 0. The settle count restarts from zero, and cpuClkEn rises exactly one settle length after the wake edge.
- R6: A wakeReq or a pdReq sampled while a settle count is running has no effect. The count neither restarts nor stops.
- R7: srcSel is captured on the first counting clock of a settle period. Any later change to srcSel leaves the length of that period unchanged.
- R8: Once cpuClkEn is 1, it stays 1, and oscEn stays 1, until a pdReq is sampled. A wakeReq while running has no effect.
- R9: cpuClkEn is never 1 while oscEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; counting happens only while oscEn is 1 |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 3 | Clock source code: 3'b011 RC, 3'b111 external, all others crystal |
| pdReq | input | 1 | Power-down request, one-cycle strobe |
| wakeReq | input | 1 | Qualified wake request, one-cycle strobe |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable; high once the clock is stable |
| pdFlag | output | 1 | Power-down bit; clears itself on wake |

## Verification
The bench sweeps all eight source codes through a full power-down and wake cycle and counts clock edges to the exact rising edge of cpuClkEn. A design that is off by one, or that maps a code to the wrong length, shows up as a wrong count. Wake and power-down strobes are injected in the middle of a count. A design that restarts or aborts on them would give a longer count, or would drop the oscillator. The source code is changed both on the first counting clock and in the middle of a count, which separates a design that captures at the right moment from one that reads srcSel live. Stray wake requests while running, and a reset in the middle of a count, cover cpuClkEn dropping when it should not and a reset that leaves state behind.

// File: rtl/osc_wake_pkg.sv
package osc_wake_pkg;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_RUN   = 2'd1,
    ST_DOWN  = 2'd2
  } wakeState_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;

  localparam logic [2:0] SEL_RC  = 3'b011;
  localparam logic [2:0] SEL_EXT = 3'b111;

  // every code that is not a known non-crystal source takes the long wait
  function automatic logic isLongSrc(input logic [2:0] sel);
    return !((sel == SEL_RC) || (sel == SEL_EXT));
  endfunction

endpackage

// File: rtl/osc_wake_count.sv
module osc_wake_count
  import osc_wake_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strb,
  input  logic [2:0] srcSel,
  output logic       term
);

  localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((1 << SHORT_W) - 1);

  logic [CNT_W-1:0] cnt;
  logic             longWait;
  logic [CNT_W-1:0] lastIdx;
  logic             capSel;

  // capture source on the first counting clock, or keep tracking while held clear
  assign capSel  = strb.clr || (strb.inc && (cnt == '0));
  assign lastIdx = longWait ? LONG_LAST : SHORT_LAST;
  assign term    = (cnt == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      longWait <= 1'b1;
    end else begin
      if (strb.clr) begin
        cnt <= '0;
      end else if (strb.inc) begin
        cnt <= cnt + 1'b1;
      end
      if (capSel) begin
        longWait <= isLongSrc(srcSel);
      end
    end
  end

  // R5: counter held cleared while the oscillator is off
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt == '0));

  // R3: a short-wait count never passes its last index
  p_short_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    !longWait |-> (cnt <= SHORT_LAST));

  // R2: the control never asks for an increment at the terminal count
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc |-> !term);

  // R7: the captured source does not move once counting is under way
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && (cnt != '0)) |=> $stable(longWait));

endmodule

// File: rtl/osc_wake_ctrl.sv
module osc_wake_ctrl
  import osc_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pdReq,
  input  logic       wakeReq,
  input  logic       term,
  output cntStrobe_t strb,
  output logic       oscEn,
  output logic       cpuClkEn,
  output logic       pdFlag
);

  wakeState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_COUNT: if (term)    stateNext = ST_RUN;
      ST_RUN:   if (pdReq)   stateNext = ST_DOWN;
      ST_DOWN:  if (wakeReq) stateNext = ST_COUNT;
      default:               stateNext = ST_COUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_COUNT;
    end else begin
      state <= stateNext;
    end
  end

  assign strb.clr = (state == ST_DOWN);
  assign strb.inc = (state == ST_COUNT) && !term;
  assign oscEn    = (state != ST_DOWN);
  assign cpuClkEn = (state == ST_RUN);
  assign pdFlag   = (state == ST_DOWN);

  // R9: no CPU clock without a running oscillator
  p_clk_needs_osc_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> oscEn);

  // R4: power-down entry stops the oscillator and sets the flag
  p_pd_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && pdReq) |=> (!oscEn && !cpuClkEn && pdFlag));

  // R5: wake restarts the oscillator with the CPU clock still held
  p_wake_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pdFlag && wakeReq) |=> (oscEn && !pdFlag && !cpuClkEn));

  // R8: the run state persists without a power-down request
  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && !pdReq) |=> cpuClkEn);

  // R6: strobes during a count neither stop the oscillator nor end the count early
  p_count_ignore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (oscEn && !cpuClkEn && !term) |=> (oscEn && !cpuClkEn));

endmodule

// File: rtl/osc_wake_timer.sv
module osc_wake_timer
  import osc_wake_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] srcSel,
  input  logic       pdReq,
  input  logic       wakeReq,
  output logic       oscEn,
  output logic       cpuClkEn,
  output logic       pdFlag
);

  cntStrobe_t strb;
  logic       term;

  osc_wake_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pdReq    (pdReq),
    .wakeReq  (wakeReq),
    .term     (term),
    .strb     (strb),
    .oscEn    (oscEn),
    .cpuClkEn (cpuClkEn),
    .pdFlag   (pdFlag)
  );

  osc_wake_count #(
    .CNT_W   (CNT_W),
    .SHORT_W (SHORT_W)
  ) i_count (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .srcSel (srcSel),
    .term   (term)
  );

endmodule

// File: tb/test_osc_wake_timer.sv
module test_osc_wake_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] srcSel = 3'b000;
  logic       pdReq = 1'b0;
  logic       wakeReq = 1'b0;
  logic       oscEn, cpuClkEn, pdFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  osc_wake_timer i_osc_wake_timer (
    .clk      (clk),
    .rstN     (rstN),
    .srcSel   (srcSel),
    .pdReq    (pdReq),
    .wakeReq  (wakeReq),
    .oscEn    (oscEn),
    .cpuClkEn (cpuClkEn),
    .pdFlag   (pdFlag)
  );

  function automatic int expLen(input logic [2:0] s);
    return ((s == 3'b011) || (s == 3'b111)) ? 256 : 1024;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts edges until cpuClkEn is seen high; optional strobe injection and source change
  task automatic runCount(input int injAt, input int chgAt, input logic [2:0] newSel,
                          output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      if (n + 1 == injAt) begin
        wakeReq = 1'b1;
        pdReq   = 1'b1;
      end
      if (n + 1 == chgAt) srcSel = newSel;
      @(posedge clk);
      n++;
      @(negedge clk);
      wakeReq = 1'b0;
      pdReq   = 1'b0;
      if (!oscEn) begin
        check(1'b0, "R6 oscEn dropped during count", 0, 1);
        break;
      end
      if (cpuClkEn) break;
    end
  endtask

  task automatic doPd(input string req);
    @(negedge clk);
    pdReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pdReq = 1'b0;
    check(!oscEn, {req, " oscEn"}, int'(oscEn), 0);
    check(!cpuClkEn, {req, " cpuClkEn"}, int'(cpuClkEn), 0);
    check(pdFlag, {req, " pdFlag"}, int'(pdFlag), 1);
  endtask

  task automatic doWake(input string req);
    wakeReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wakeReq = 1'b0;
    check(oscEn && !pdFlag && !cpuClkEn, {req, " wake state"},
          {29'd0, oscEn, pdFlag, cpuClkEn}, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(oscEn && !cpuClkEn && !pdFlag, "R1 reset state",
          {29'd0, oscEn, cpuClkEn, pdFlag}, 4);
    rstN = 1'b1;
    runCount(0, 0, 3'b000, n);
    check(n == 1024, "R1 R2 startup length", n, 1024);

    // R2 R3: sweep all source codes through power-down and wake
    for (int c = 0; c < 8; c++) begin
      srcSel = 3'(c);
      doPd("R4 entry");
      repeat (5) @(negedge clk);
      check(!oscEn && !cpuClkEn && pdFlag, "R4 hold in power-down",
            {29'd0, oscEn, cpuClkEn, pdFlag}, 1);
      doWake("R5");
      runCount(0, 0, 3'b000, n);
      check(n == expLen(3'(c)), (expLen(3'(c)) == 256) ? "R3 R5 short length"
            : "R2 R5 long length", n, expLen(3'(c)));
    end

    // R6: strobes mid-count are ignored
    srcSel = 3'b011;
    doPd("R4 entry");
    doWake("R5");
    runCount(100, 0, 3'b000, n);
    check(n == 256, "R6 strobes mid-count short", n, 256);
    srcSel = 3'b001;
    doPd("R4 entry");
    doWake("R5");
    runCount(700, 0, 3'b000, n);
    check(n == 1024, "R6 strobes mid-count long", n, 1024);

    // R7: capture on first counting clock, later changes ignored
    srcSel = 3'b000;
    doPd("R4 entry");
    doWake("R5");
    runCount(0, 1, 3'b011, n);
    check(n == 256, "R7 captured at first count clock", n, 256);
    doPd("R4 entry");
    doWake("R5");
    runCount(0, 5, 3'b000, n);
    check(n == 256, "R7 late change short to long", n, 256);
    srcSel = 3'b010;
    doPd("R4 entry");
    doWake("R5");
    runCount(0, 3, 3'b111, n);
    check(n == 1024, "R7 late change long to short", n, 1024);

    // R8: running state holds through stray wake requests
    for (int k = 0; k < 50; k++) begin
      wakeReq = (k % 3 == 0);
      @(posedge clk);
      @(negedge clk);
      wakeReq = 1'b0;
      check(cpuClkEn && oscEn && !pdFlag, "R8 run hold",
            {29'd0, cpuClkEn, oscEn, pdFlag}, 6);
    end

    // R1: reset mid-count restarts with the current source
    srcSel = 3'b111;
    doPd("R4 entry");
    doWake("R5");
    repeat (40) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(oscEn && !cpuClkEn && !pdFlag, "R1 reset mid-count state",
          {29'd0, oscEn, cpuClkEn, pdFlag}, 4);
    rstN = 1'b1;
    runCount(0, 0, 3'b000, n);
    check(n == 256, "R1 R3 startup length after reset", n, 256);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule